// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single storage cell that hardware threads use as a small mailbox. It holds a power-of-two number of data words in a circular buffer. It also holds a tag word with an empty flag, a full flag, a free software flag and the current occupancy. Each request carries a view code, which selects how the cell is accessed. The raw view reads or patches data without moving the queue. The tag view reads or loads the tag word. The two queue views push on write and pop on read: one stalls the requester when it cannot proceed, the other never stalls.

A requester that stalls has its thread ID recorded in a bitmask. The next queue access that does not stall, whether read or write, returns that bitmask as a one-cycle wake pulse and clears the record. A request is sampled on a rising clock edge. The response (read data, stall and wake mask) is registered and is valid for exactly the following cycle. It is all zeros when no request was made.

Top module: `tagged_fifo_cell`

## Requirements
- R1: After reset, a tag-view read returns E=1, mode flag=1, occupancy 0, T=0, F=0 and a depth code equal to log2(DEPTH).
- R2: A tag-view read (view code 1) returns the depth code in bits 31:28, the occupancy from bit 18 upward, the mode flag (always 1) in bit 17, T in bit 16, F in bit 1 and E in bit 0, with all other bits zero.
- R3: A tag-view write loads T, F and E from write-data bits 16, 1 and 0. When bit 0 is 1 the occupancy becomes zero; buffer contents and head position are kept.
- R4: A queue read (view code 2 or 3) that does not stall clears F. It returns and removes the head entry when occupancy is nonzero and returns 0 otherwise. E is set when the occupancy is zero afterwards.
- R5: A read with view code 2 while E=1 stalls the requester: the stall output is 1, the requester's thread bit is added to the blocked record, F is cleared and nothing is removed.
- R6: A queue write that does not stall clears E. It appends the data when occupancy is below DEPTH and otherwise discards it. F is set when the occupancy equals DEPTH afterwards. Any write returns zero read data.
- R7: A write with view code 2 while F=1 stalls the requester and records its thread bit. E is cleared and nothing is stored.
- R8: Every non-stalling queue access outputs the blocked record as the wake mask for one cycle and clears the record. A stalling access never outputs a wake mask.
- R9: A raw-view read (view code 0) returns the entry at the head without removing it.
- R10: A raw-view write replaces the most recently appended entry when occupancy is nonzero, and has no effect when occupancy is zero.
- R11: Responses appear in the cycle after the request. Idle cycles, and view codes 4 to 15, give zero read data, no stall and no wake, and change no state.
- R12: Head and tail positions wrap modulo DEPTH, so FIFO order is kept across the wrap, and the occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqView | input | 4 | View code: 0 raw, 1 tag, 2 queue stalling, 3 queue non-stalling |
| reqWdata | input | DW | Write data |
| reqThread | input | $clog2(NTHR) | Requesting thread ID |
| rdData | output | DW | Read data of the previous cycle's request |
| stall | output | 1 | The previous cycle's request must wait |
| wakeMask | output | NTHR | One-cycle pulse of threads to wake |

## Verification
The assertions assume the request inputs are known (never X) whenever reset is released, and that a thread whose request stalled is retried later rather than relying on the cell to replay it. The stimulus drives every input to a defined value on each falling edge, including idle cycles. Stalled requesters are simply issued again later, as fresh requests, in both the directed phases and the random phase. Thread IDs always fall inside the port width, so every recorded bit maps to a real thread.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  typedef enum logic [3:0] {
    VIEW_RAW     = 4'd0,
    VIEW_TAG     = 4'd1,
    VIEW_EF_WAIT = 4'd2,
    VIEW_EF_TRY  = 4'd3
  } view_e;

  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_MODE_BIT  = 17;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_E_BIT     = 0;

  typedef struct packed {
    logic pop;
    logic push;
    logic rawWr;
    logic cntClear;
    logic selHead;
    logic selTag;
  } cellStrobes_t;

endpackage

// File: rtl/tfc_ctrl.sv
module tfc_ctrl
  import tfc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NTHR  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1,
  localparam int TIDW = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [3:0]       reqView,
  input  logic [TIDW-1:0]  reqThread,
  input  logic             wrT,
  input  logic             wrF,
  input  logic             wrE,
  input  logic [CNTW-1:0]  fifoCount,
  output cellStrobes_t     strb,
  output logic             flagT,
  output logic             flagF,
  output logic             flagE,
  output logic             stall,
  output logic [NTHR-1:0]  wakeMask
);

  logic nxtT, nxtF, nxtE;
  logic doStall, doWake;
  logic cntZero, cntFull, cntLast, cntOne;
  logic isWait;
  logic [NTHR-1:0] blocked;
  logic [NTHR-1:0] tidBit;

  assign cntZero = (fifoCount == '0);
  assign cntOne  = (fifoCount == CNTW'(1));
  assign cntFull = (fifoCount == CNTW'(DEPTH));
  assign cntLast = (fifoCount == CNTW'(DEPTH - 1));
  assign isWait  = (reqView == VIEW_EF_WAIT);
  assign tidBit  = NTHR'(1) << reqThread;

  always_comb begin
    strb    = '0;
    nxtT    = flagT;
    nxtF    = flagF;
    nxtE    = flagE;
    doStall = 1'b0;
    doWake  = 1'b0;
    if (reqValid) begin
      case (reqView)
        VIEW_RAW: begin
          if (reqWrite) strb.rawWr = !cntZero;
          else          strb.selHead = 1'b1;
        end
        VIEW_TAG: begin
          if (reqWrite) begin
            nxtT          = wrT;
            nxtF          = wrF;
            nxtE          = wrE;
            strb.cntClear = wrE;
          end else begin
            strb.selTag = 1'b1;
          end
        end
        VIEW_EF_WAIT, VIEW_EF_TRY: begin
          if (!reqWrite) begin
            nxtF = 1'b0;
            if (isWait && flagE) begin
              doStall = 1'b1;
            end else begin
              doWake = 1'b1;
              if (!cntZero) begin
                strb.pop     = 1'b1;
                strb.selHead = 1'b1;
                if (cntOne) nxtE = 1'b1;
              end else begin
                nxtE = 1'b1;
              end
            end
          end else begin
            nxtE = 1'b0;
            if (isWait && flagF) begin
              doStall = 1'b1;
            end else begin
              doWake = 1'b1;
              if (!cntFull) begin
                strb.push = 1'b1;
                if (cntLast) nxtF = 1'b1;
              end else begin
                nxtF = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagT    <= 1'b0;
      flagF    <= 1'b0;
      flagE    <= 1'b1;
      blocked  <= '0;
      stall    <= 1'b0;
      wakeMask <= '0;
    end else begin
      flagT    <= nxtT;
      flagF    <= nxtF;
      flagE    <= nxtE;
      stall    <= doStall;
      wakeMask <= doWake ? blocked : '0;
      if (doStall)     blocked <= blocked | tidBit;
      else if (doWake) blocked <= '0;
    end
  end

endmodule

// File: rtl/tfc_datapath.sv
module tfc_datapath
  import tfc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  cellStrobes_t    strb,
  input  logic [DW-1:0]   wrData,
  input  logic            flagT,
  input  logic            flagF,
  input  logic            flagE,
  output logic [CNTW-1:0] fifoCount,
  output logic [DW-1:0]   rdData
);

  localparam logic [3:0] DEPTH_CODE = 4'(AW);

  logic [AW-1:0] head;
  logic [AW-1:0] tailSlot;
  logic [AW-1:0] newestSlot;
  logic [DW-1:0] slotQ [DEPTH];
  logic [DW-1:0] tagWord;

  assign tailSlot   = head + AW'(fifoCount);
  assign newestSlot = head + AW'(fifoCount) - AW'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic wrEn;
    assign wrEn = (strb.push  && (tailSlot   == AW'(g))) ||
                  (strb.rawWr && (newestSlot == AW'(g)));
    always_ff @(posedge clk) begin
      if (!rstN)     slotQ[g] <= '0;
      else if (wrEn) slotQ[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      fifoCount <= '0;
    end else begin
      if (strb.pop) begin
        head      <= head + AW'(1);
        fifoCount <= fifoCount - CNTW'(1);
      end else if (strb.push) begin
        fifoCount <= fifoCount + CNTW'(1);
      end else if (strb.cntClear) begin
        fifoCount <= '0;
      end
    end
  end

  always_comb begin
    tagWord                              = '0;
    tagWord[TAG_DEPTH_LSB +: 4]          = DEPTH_CODE;
    tagWord[TAG_CNT_LSB +: CNTW]         = fifoCount;
    tagWord[TAG_MODE_BIT]                = 1'b1;
    tagWord[TAG_T_BIT]                   = flagT;
    tagWord[TAG_F_BIT]                   = flagF;
    tagWord[TAG_E_BIT]                   = flagE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (strb.selHead) rdData <= slotQ[head];
    else if (strb.selTag)  rdData <= tagWord;
    else                   rdData <= '0;
  end

endmodule

// File: rtl/tagged_fifo_cell.sv
module tagged_fifo_cell
  import tfc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int NTHR  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1,
  localparam int TIDW = $clog2(NTHR)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [3:0]      reqView,
  input  logic [DW-1:0]   reqWdata,
  input  logic [TIDW-1:0] reqThread,
  output logic [DW-1:0]   rdData,
  output logic            stall,
  output logic [NTHR-1:0] wakeMask
);

  cellStrobes_t    strb;
  logic            flagT, flagF, flagE;
  logic [CNTW-1:0] fifoCount;

  tfc_ctrl #(.DEPTH(DEPTH), .NTHR(NTHR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqView   (reqView),
    .reqThread (reqThread),
    .wrT       (reqWdata[TAG_T_BIT]),
    .wrF       (reqWdata[TAG_F_BIT]),
    .wrE       (reqWdata[TAG_E_BIT]),
    .fifoCount (fifoCount),
    .strb      (strb),
    .flagT     (flagT),
    .flagF     (flagF),
    .flagE     (flagE),
    .stall     (stall),
    .wakeMask  (wakeMask)
  );

  tfc_datapath #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (reqWdata),
    .flagT     (flagT),
    .flagF     (flagF),
    .flagE     (flagE),
    .fifoCount (fifoCount),
    .rdData    (rdData)
  );

endmodule

// File: rtl/tfc_checker.sv
module tfc_checker
  import tfc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int NTHR  = 16,
  localparam int CNTW = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqWrite,
  input logic [3:0]      reqView,
  input logic [DW-1:0]   rdData,
  input logic            stall,
  input logic [NTHR-1:0] wakeMask,
  input logic [CNTW-1:0] fifoCount
);

  logic efReq;
  assign efReq = reqValid && (reqView == VIEW_EF_WAIT || reqView == VIEW_EF_TRY);

  assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqView == VIEW_EF_WAIT) |=> !stall);

  assert_stall_wake_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(stall && (wakeMask != '0)));

  assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    !efReq |=> (wakeMask == '0));

  assert_mode_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqView == VIEW_TAG) |=> rdData[TAG_MODE_BIT]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (rdData == '0 && !stall && wakeMask == '0));

  assert_write_no_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rdData == '0));

  assert_count_in_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNTW'(DEPTH));

endmodule

bind tagged_fifo_cell tfc_checker #(.DEPTH(DEPTH), .DW(DW), .NTHR(NTHR)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqView   (reqView),
  .rdData    (rdData),
  .stall     (stall),
  .wakeMask  (wakeMask),
  .fifoCount (fifoCount)
);

// File: tb/sim_tagged_fifo_cell.sv
module sim_tagged_fifo_cell;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int DW    = 32;
  localparam int NTHR  = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int TIDW  = $clog2(NTHR);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqWrite = 1'b0;
  logic [3:0]      reqView = '0;
  logic [DW-1:0]   reqWdata = '0;
  logic [TIDW-1:0] reqThread = '0;
  logic [DW-1:0]   rdData;
  logic            stall;
  logic [NTHR-1:0] wakeMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  int unsigned     mdl [DEPTH];
  int              mHead = 0;
  int              mCnt  = 0;
  bit              mE = 1, mF = 0, mT = 0;
  logic [NTHR-1:0] mBlk = '0;
  logic [DW-1:0]   expRd = '0;
  logic            expStall = 0;
  logic [NTHR-1:0] expWake = '0;
  string           expTag = "R11";
  string           phase = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_fifo_cell #(.DEPTH(DEPTH), .DW(DW), .NTHR(NTHR)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqView(reqView), .reqWdata(reqWdata), .reqThread(reqThread),
    .rdData(rdData), .stall(stall), .wakeMask(wakeMask)
  );

  task automatic compareNow();
    string t;
    t = (phase == "") ? expTag : {phase, " ", expTag};
    checks++;
    if (rdData !== expRd) begin
      fails++;
      $display("FAIL %s rdData actual=%h expected=%h", t, rdData, expRd);
    end
    checks++;
    if (stall !== expStall) begin
      fails++;
      $display("FAIL %s stall actual=%b expected=%b", t, stall, expStall);
    end
    checks++;
    if (wakeMask !== expWake) begin
      fails++;
      $display("FAIL %s wakeMask actual=%h expected=%h", t, wakeMask, expWake);
    end
  endtask

  task automatic modelApply(bit v, bit w, int vw, logic [DW-1:0] d, int tid);
    expRd = '0; expStall = 0; expWake = '0; expTag = "R11";
    if (!v) return;
    case (vw)
      0: if (w) begin
           expTag = "R10";
           if (mCnt > 0) mdl[(mHead + mCnt - 1) % DEPTH] = d;
         end else begin
           expTag = "R9";
           expRd = mdl[mHead];
         end
      1: if (w) begin
           expTag = "R3";
           mT = d[16]; mF = d[1]; mE = d[0];
           if (mE) mCnt = 0;
         end else begin
           expTag = "R2";
           expRd = (DW'(AW) << 28) | (DW'(mCnt) << 18) | (DW'(1) << 17) |
                   (DW'(mT) << 16) | (DW'(mF) << 1) | DW'(mE);
         end
      2, 3: if (!w) begin
           expTag = "R4";
           mF = 0;
           if (vw == 2 && mE) begin
             expTag = "R5"; expStall = 1; mBlk[tid] = 1'b1;
           end else begin
             expWake = mBlk; mBlk = '0;
             if (expWake != '0) expTag = "R4 R8";
             if (mCnt > 0) begin
               if (mHead == DEPTH - 1) expTag = {expTag, " R12"};
               expRd = mdl[mHead];
               mHead = (mHead + 1) % DEPTH;
               mCnt--;
             end
             if (mCnt == 0) mE = 1;
           end
         end else begin
           expTag = "R6";
           mE = 0;
           if (vw == 2 && mF) begin
             expTag = "R7"; expStall = 1; mBlk[tid] = 1'b1;
           end else begin
             expWake = mBlk; mBlk = '0;
             if (expWake != '0) expTag = "R6 R8";
             if (mCnt < DEPTH) begin
               mdl[(mHead + mCnt) % DEPTH] = d;
               mCnt++;
             end
             if (mCnt == DEPTH) mF = 1;
           end
         end
      default: expTag = "R11";
    endcase
  endtask

  task automatic step(bit v, bit w, int vw, logic [DW-1:0] d, int tid);
    @(negedge clk);
    compareNow();
    reqValid  = v;
    reqWrite  = w;
    reqView   = 4'(vw);
    reqWdata  = d;
    reqThread = TIDW'(tid);
    modelApply(v, w, vw, d, tid);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset image of the tag word
    phase = "R1";
    step(1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    phase = "";
    // R4: empty non-stalling read returns 0
    step(1, 0, 3, 0, 1);
    // R5: two stalled readers are recorded
    step(1, 0, 2, 0, 3);
    step(1, 0, 2, 0, 5);
    // R8: a write wakes both
    step(1, 1, 3, 32'hA1, 7);
    // R6: fill to full
    for (int i = 0; i < DEPTH - 1; i++) step(1, 1, 3, 32'hB0 + i, 0);
    step(1, 0, 1, 0, 0);
    step(1, 1, 3, 32'hDEAD, 0);       // R6 discarded when full
    step(1, 1, 2, 32'hBEEF, 2);       // R7 stall when F set
    step(1, 0, 0, 0, 0);              // R9 raw read head
    step(1, 1, 0, 32'h5555, 0);       // R10 patch newest
    step(1, 0, 1, 0, 0);
    // R4/R8: drain all, first pop wakes thread 2
    for (int i = 0; i < DEPTH; i++) step(1, 0, 3, 0, 0);
    step(1, 0, 1, 0, 0);
    // R10: raw write on empty has no effect
    step(1, 1, 0, 32'h7777, 0);
    step(1, 0, 0, 0, 0);
    // R12: push/pop across the wrap point
    phase = "R12";
    for (int i = 0; i < 3 * DEPTH; i++) begin
      step(1, 1, 3, 32'hC000 + i, 0);
      step(1, 1, 3, 32'hD000 + i, 0);
      step(1, 0, 2, 0, 0);
    end
    step(1, 0, 1, 0, 0);
    phase = "";
    // R3: tag writes
    step(1, 1, 1, 32'h0001_0001, 0);  // T=1, E=1 clears count
    step(1, 0, 1, 0, 0);
    step(1, 1, 1, 32'h0000_0002, 0);  // F=1 with empty buffer
    step(1, 1, 2, 32'h99, 9);         // R7 stalls on F
    step(1, 0, 1, 0, 0);
    step(1, 1, 3, 32'h42, 0);         // R8 wake thread 9
    step(1, 0, 0, 0, 0);
    // R11: unused view codes
    step(1, 1, 7, 32'hFFFF_FFFF, 0);
    step(1, 0, 9, 0, 0);
    step(1, 0, 1, 0, 0);
    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int sel;
      int vw;
      sel = $urandom_range(0, 9);
      vw = (sel < 6) ? (2 + (sel % 2)) : (sel == 6) ? 0 : (sel == 7) ? 1 : (sel == 8) ? 12 : 3;
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, vw,
           (vw == 1) ? DW'($urandom_range(0, 3)) : DW'($urandom()),
           $urandom_range(0, NTHR - 1));
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule